// File: doc/BRIEF.md
# Variable Pulse-Width Arbitrating Frame Transmitter

This block places one message frame on a single-wire, wired-OR bus as a sequence of variable pulse-width symbols. A frame opens with a long active start symbol. Each data bit then becomes one symbol whose level alternates between passive and active and whose duration carries the bit value. The frame closes with a passive end-of-data interval. The caller supplies every byte, including its own check byte. Bytes are fetched one at a time through a take pulse, so no frame buffer is needed.

Several nodes may begin a frame together. The node reads the synchronized bus level back while it transmits. If the bus goes active while this node holds it passive, past a short grace window at the start of the symbol, then another node is still driving an active symbol or has started its next one early. The node counts this as lost arbitration and releases the bus for the rest of the frame. Each active symbol must also appear on the bus input within a fixed echo window. If it does not, the node reports a no-echo error and stops. All timing is counted in ticks of one microsecond from the `tick_us` input.

Top module: `vpw_arb_tx`

## Requirements
- R1: After reset, `bus_drive`, `busy`, `done`, `lost`, `no_echo` and `byte_take` are all 0.
- R2: A `start` pulse while idle captures `tx_byte`/`tx_last` and raises `busy` and `bus_drive` (1 = active) on the next clock. The start symbol is active for 200 ticks, counting from the first tick after the start edge.
- R3: Data symbols follow the start symbol. The first is passive and the level then alternates. A passive symbol lasts 64 ticks for bit 1 and 128 ticks for bit 0. An active symbol lasts 128 ticks for bit 1 and 64 ticks for bit 0.
- R4: Each byte is sent most significant bit first. `byte_take` pulses once per captured byte: once after `start`, and once after the eighth symbol of each byte that had `tx_last` = 0. The byte held when `tx_last` = 1 is the final one.
- R5: After the last data symbol the bus stays passive for 200 ticks. Then `busy` falls and `done` rises in the same cycle, and no other status flag is set.
- R6: During a passive data symbol, the synchronized bus input can be seen active at 16 or more ticks into the symbol. When that happens, `lost` is set, `busy` falls and `bus_drive` returns to 0 in that same clock. No further active symbol is driven in that frame.
- R7: `done`, `lost` and `no_echo` hold their value until the next accepted `start`, which clears all three.
- R8: During any active symbol, the bus input may stay passive for 60 ticks. When it does, `no_echo` is set, `bus_drive` is released and `busy` falls.
- R9: A `start` pulse while `busy` is high is ignored. The symbols on the bus stay those of the frame already in progress, and no extra byte is taken.
- R10: A second node driving exactly the same symbols, slightly delayed, causes no loss. The frame completes with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| start | input | 1 | Begin a frame (accepted only while idle) |
| tx_byte | input | 8 | Byte offered to the transmitter |
| tx_last | input | 1 | Marks `tx_byte` as the final byte of the frame |
| byte_take | output | 1 | Pulse: the offered byte was captured, present the next |
| bus_in | input | 1 | Raw bus level read back, 1 = active |
| bus_drive | output | 1 | Open-drain drive, 1 = pull bus active |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame sent completely without contention |
| lost | output | 1 | Arbitration lost |
| no_echo | output | 1 | Own active symbol never seen on the bus |

## Verification
The main path is swept over a spread of single-byte values plus two- and three-byte frames. Every symbol width is measured in clock cycles, which separates bit polarity, the level alternation, MSB-first order and byte hand-over. One competing pattern raises the bus early in a passive symbol, and another stretches an active symbol past this node's own. These show that both kinds of mismatch end the frame with the bus released and that the loss flag persists. A delayed mirror of the node's own drive shows that an identical competitor does not cause a loss. A bus stuck passive exercises the echo timeout. A start pulse in mid-frame, with a different byte offered, shows that an extra start is ignored.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SOF  = 2'd1,
    ST_DATA = 2'd2,
    ST_EOD  = 2'd3
  } tx_state_t;

  // A symbol is long when its level and bit value agree:
  // active carries 1 as long, passive carries 0 as long.
  function automatic logic long_symbol(input logic active, input logic bit_val);
    return active ? bit_val : ~bit_val;
  endfunction

endpackage

// File: rtl/vpw_bus_sync.sv
module vpw_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/vpw_symbol_timer.sv
module vpw_symbol_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (tick & (cnt_q != {CNT_W{1'b1}}));
    cnt_d  = load ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count  = cnt_q;
  assign expire = tick & (cnt_q == target - CNT_W'(1));

endmodule

// File: rtl/vpw_byte_shifter.sv
module vpw_byte_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_first,
  input  logic              advance,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              last_in,
  output logic              cur_bit,
  output logic              frame_end,
  output logic              byte_take
);

  localparam int BCW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [BCW-1:0] BIT_TOP = BCW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BCW-1:0]    bc_q, bc_d;
  logic              last_q, last_d;
  logic              take_q, take_d;
  logic              at_top;
  logic              refill;

  always_comb begin
    at_top = (bc_q == BIT_TOP);
    refill = load_first | (advance & at_top & ~last_q);
    sh_d   = sh_q;
    bc_d   = bc_q;
    last_d = last_q;
    take_d = refill;
    if (refill) begin
      sh_d   = byte_in;
      bc_d   = '0;
      last_d = last_in;
    end else if (advance & ~at_top) begin
      sh_d = {sh_q[BYTE_W-2:0], 1'b0};
      bc_d = bc_q + BCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bc_q   <= '0;
      last_q <= 1'b0;
      take_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bc_q   <= bc_d;
      last_q <= last_d;
      take_q <= take_d;
    end
  end

  assign cur_bit   = sh_q[BYTE_W-1];
  assign frame_end = last_q & at_top;
  assign byte_take = take_q;

endmodule

// File: rtl/vpw_arb_tx.sv
module vpw_arb_tx #(
  parameter int BYTE_W      = 8,
  parameter int SHORT_US    = 64,
  parameter int LONG_US     = 128,
  parameter int SOF_US      = 200,
  parameter int EOD_US      = 200,
  parameter int ECHO_US     = 60,
  parameter int GRACE_US    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_last,
  output logic              byte_take,
  input  logic              bus_in,
  output logic              bus_drive,
  output logic              busy,
  output logic              done,
  output logic              lost,
  output logic              no_echo
);
  import vpw_tx_pkg::*;

  localparam int MAX_A  = (SOF_US > EOD_US) ? SOF_US : EOD_US;
  localparam int MAX_B  = (LONG_US > MAX_A) ? LONG_US : MAX_A;
  localparam int MAX_US = (ECHO_US > MAX_B) ? ECHO_US : MAX_B;
  localparam int TW     = $clog2(MAX_US + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // bus read-back
  logic bus_s;

  vpw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .din  (bus_in),
    .dout (bus_s)
  );

  // state
  tx_state_t st_q, st_d;
  logic      act_q, act_d;
  logic      drv_q, drv_d;
  logic      echo_q, echo_d;
  logic      done_q, done_d;
  logic      lost_q, lost_d;
  logic      nech_q, nech_d;

  logic          tmr_load;
  logic [TW-1:0] tmr_target;
  logic [TW-1:0] tmr_count;
  logic          tmr_expire;
  logic          sh_first, sh_adv;
  logic          cur_bit, frame_end;

  vpw_symbol_timer #(.CNT_W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_core_n),
    .tick  (tick_us),
    .load  (tmr_load),
    .target(tmr_target),
    .count (tmr_count),
    .expire(tmr_expire)
  );

  vpw_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load_first(sh_first),
    .advance   (sh_adv),
    .byte_in   (tx_byte),
    .last_in   (tx_last),
    .cur_bit   (cur_bit),
    .frame_end (frame_end),
    .byte_take (byte_take)
  );

  // symbol duration for the current state
  always_comb begin
    unique case (st_q)
      ST_SOF:  tmr_target = TW'(SOF_US);
      ST_EOD:  tmr_target = TW'(EOD_US);
      ST_DATA: tmr_target = long_symbol(act_q, cur_bit) ? TW'(LONG_US) : TW'(SHORT_US);
      default: tmr_target = TW'(SHORT_US);
    endcase
  end

  // contention and echo monitors
  logic driving_active;
  logic echo_fail;
  logic clash;

  always_comb begin
    driving_active = (st_q == ST_SOF) | ((st_q == ST_DATA) & act_q);
    echo_fail      = driving_active & ~echo_q & ~bus_s & tick_us &
                     (tmr_count == TW'(ECHO_US - 1));
    clash          = (st_q == ST_DATA) & ~act_q & bus_s &
                     (tmr_count >= TW'(GRACE_US));
  end

  // next state
  always_comb begin
    st_d     = st_q;
    act_d    = act_q;
    drv_d    = drv_q;
    echo_d   = echo_q | bus_s;
    done_d   = done_q;
    lost_d   = lost_q;
    nech_d   = nech_q;
    tmr_load = 1'b0;
    sh_first = 1'b0;
    sh_adv   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d     = ST_SOF;
          drv_d    = 1'b1;
          echo_d   = 1'b0;
          done_d   = 1'b0;
          lost_d   = 1'b0;
          nech_d   = 1'b0;
          tmr_load = 1'b1;
          sh_first = 1'b1;
        end
      end
      ST_SOF: begin
        if (echo_fail) begin
          st_d   = ST_IDLE;
          drv_d  = 1'b0;
          nech_d = 1'b1;
        end else if (tmr_expire) begin
          st_d     = ST_DATA;
          act_d    = 1'b0;
          drv_d    = 1'b0;
          echo_d   = 1'b0;
          tmr_load = 1'b1;
        end
      end
      ST_DATA: begin
        if (echo_fail) begin
          st_d   = ST_IDLE;
          drv_d  = 1'b0;
          nech_d = 1'b1;
        end else if (clash) begin
          st_d   = ST_IDLE;
          drv_d  = 1'b0;
          lost_d = 1'b1;
        end else if (tmr_expire) begin
          tmr_load = 1'b1;
          echo_d   = 1'b0;
          if (frame_end) begin
            st_d  = ST_EOD;
            drv_d = 1'b0;
          end else begin
            sh_adv = 1'b1;
            act_d  = ~act_q;
            drv_d  = ~act_q;
          end
        end
      end
      ST_EOD: begin
        if (tmr_expire) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q   <= ST_IDLE;
      act_q  <= 1'b0;
      drv_q  <= 1'b0;
      echo_q <= 1'b0;
      done_q <= 1'b0;
      lost_q <= 1'b0;
      nech_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      act_q  <= act_d;
      drv_q  <= drv_d;
      echo_q <= echo_d;
      done_q <= done_d;
      lost_q <= lost_d;
      nech_q <= nech_d;
    end
  end

  assign bus_drive = drv_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign lost      = lost_q;
  assign no_echo   = nech_q;

endmodule

// File: rtl/vpw_arb_tx_chk.sv
module vpw_arb_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic bus_drive,
  input logic busy,
  input logic done,
  input logic lost,
  input logic no_echo
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_drive);

  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, lost, no_echo}) <= 1);

  assert_release_on_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> (!bus_drive && !busy));

  assert_lost_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !start) |=> lost);

  assert_done_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_flags_clear_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(done || lost || no_echo));

  assert_release_on_no_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_echo) |-> (!bus_drive && !busy));

endmodule

bind vpw_arb_tx vpw_arb_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .bus_drive(bus_drive),
  .busy     (busy),
  .done     (done),
  .lost     (lost),
  .no_echo  (no_echo)
);

// File: tb/vpw_arb_tx_bench.sv
module vpw_arb_tx_bench;

  localparam int D = 2;   // clock cycles per microsecond tick

  logic       clk;
  logic       rst_n;
  logic       tick_us;
  logic       start;
  logic [7:0] tx_byte;
  logic       tx_last;
  logic       byte_take;
  logic       bus_in;
  logic       bus_drive;
  logic       busy;
  logic       done;
  logic       lost;
  logic       no_echo;
  logic       other_drv;
  logic       stuck;

  assign bus_in = stuck ? 1'b0 : (bus_drive | other_drv);

  vpw_arb_tx u_vpw_arb_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_us  (tick_us),
    .start    (start),
    .tx_byte  (tx_byte),
    .tx_last  (tx_last),
    .byte_take(byte_take),
    .bus_in   (bus_in),
    .bus_drive(bus_drive),
    .busy     (busy),
    .done     (done),
    .lost     (lost),
    .no_echo  (no_echo)
  );

  int checks = 0;
  int errors = 0;

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  initial begin
    tick_us = 1'b0;
    forever begin
      for (int p = 0; p < D; p++) begin
        @(negedge clk);
        tick_us = (p == 0);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic [7:0] fb [0:3];
  int ts [0:47];
  int nts, takes, rises, exitc, xmark;
  logic l1, dn1, ne1, b1;

  // mode: 0 alone, 1 mirror, 2 early edge in first passive, 3 stretched active
  task automatic run_frame(input int n, input int mode, input int poke);
    int  cyc;
    int  idx;
    logic prev;
    @(negedge clk);
    tx_byte = fb[0];
    tx_last = (n == 1);
    start   = 1'b1;
    idx = 0; nts = 0; cyc = 0; takes = 0; rises = 0; xmark = 0;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      start = (poke != 0 && cyc == poke);
      if (poke != 0 && cyc == poke) tx_byte = ~tx_byte;
      if (cyc == 1) begin
        l1 = lost; dn1 = done; ne1 = no_echo; b1 = busy;
      end
      if (byte_take) begin
        takes++;
        idx++;
        if (idx < n) begin
          tx_byte = fb[idx];
          tx_last = (idx == n - 1);
        end
      end
      if (bus_drive != prev && nts < 47) begin
        ts[nts] = cyc;
        nts++;
        prev = bus_drive;
        if (bus_drive) rises++;
      end
      case (mode)
        1: other_drv = bus_drive;
        2: if (nts == 2 && cyc == ts[1] + 30 * D) begin
             other_drv = 1'b1;
             xmark = cyc;
           end
        3: if (nts == 3 && cyc == ts[2]) begin
             other_drv = 1'b1;
             xmark = cyc;
           end else if (xmark != 0 && cyc == xmark + 128 * D) begin
             other_drv = 1'b0;
           end
        default: ;
      endcase
      if (!busy) begin
        if (nts < 47) begin
          ts[nts] = cyc;
          nts++;
        end
        break;
      end
    end
    exitc = cyc;
    start = 1'b0;
    other_drv = 1'b0;
  endtask

  function automatic int data_width(input int g);
    logic b;
    logic act;
    logic lng;
    b   = fb[g / 8][7 - (g % 8)];
    act = (g % 2) == 1;
    lng = act ? b : ~b;
    return (lng ? 128 : 64) * D;
  endfunction

  task automatic check_normal(input int n, input string tag);
    int exp_n;
    exp_n = 8 * n + 3;
    chk(b1 == 1'b1, "R2 busy after start", int'(b1), 1);
    chk(nts == exp_n, {tag, " edge count"}, nts, exp_n);
    if (nts == exp_n) begin
      chk(((ts[1] - ts[0]) + D - 1) / D == 200, "R2 start symbol ticks",
          ((ts[1] - ts[0]) + D - 1) / D, 200);
      for (int g = 0; g < 8 * n; g++) begin
        chk(ts[g + 2] - ts[g + 1] == data_width(g), {tag, " data symbol width"},
            ts[g + 2] - ts[g + 1], data_width(g));
      end
      chk(ts[8 * n + 2] - ts[8 * n + 1] == 200 * D, "R5 end-of-data length",
          ts[8 * n + 2] - ts[8 * n + 1], 200 * D);
    end
    chk(done == 1'b1 && lost == 1'b0 && no_echo == 1'b0, "R5 done only",
        {done, lost, no_echo}, 3'b100);
    chk(takes == n, "R4 byte_take count", takes, n);
  endtask

  initial begin
    int highs;
    rst_n = 1'b0;
    start = 1'b0;
    tx_byte = 8'h00;
    tx_last = 1'b0;
    other_drv = 1'b0;
    stuck = 1'b0;
    repeat (5) @(negedge clk);
    chk({bus_drive, busy, done, lost, no_echo, byte_take} == 6'b0, "R1 reset outputs",
        {bus_drive, busy, done, lost, no_echo, byte_take}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({bus_drive, busy, done, lost, no_echo, byte_take} == 6'b0, "R1 after release",
        {bus_drive, busy, done, lost, no_echo, byte_take}, 0);

    // R3 sweep over single-byte values
    for (int k = 0; k < 24; k++) begin
      fb[0] = 8'((k * 37 + 5) % 256);
      if (k == 0) fb[0] = 8'h00;
      if (k == 1) fb[0] = 8'hFF;
      run_frame(1, 0, 0);
      check_normal(1, "R3");
    end

    // R4 multibyte, MSB first with byte hand-over
    fb[0] = 8'h3C; fb[1] = 8'h81;
    run_frame(2, 0, 0);
    check_normal(2, "R4");
    fb[0] = 8'hE1; fb[1] = 8'h07; fb[2] = 8'h96;
    run_frame(3, 0, 0);
    check_normal(3, "R4");

    // R10 identical competitor
    fb[0] = 8'h5A; fb[1] = 8'hC3;
    run_frame(2, 1, 0);
    check_normal(2, "R10");
    chk(lost == 1'b0, "R10 no loss with mirror", int'(lost), 0);

    // R9 start while busy ignored
    fb[0] = 8'hA5;
    run_frame(1, 0, 300 * D);
    check_normal(1, "R9");

    // R6 early rising edge in a passive symbol
    fb[0] = 8'h80;
    run_frame(1, 2, 0);
    chk(lost == 1'b1 && busy == 1'b0 && bus_drive == 1'b0, "R6 lost and released",
        {lost, busy, bus_drive}, 3'b100);
    chk(exitc - xmark >= 2 && exitc - xmark <= 4, "R6 loss latency cycles", exitc - xmark, 3);
    chk(rises == 1, "R6 no active symbol after start", rises, 1);
    highs = 0;
    repeat (300 * D) begin
      @(negedge clk);
      if (bus_drive) highs++;
    end
    chk(highs == 0, "R6 silent after loss", highs, 0);
    chk(lost == 1'b1 && done == 1'b0, "R7 lost held", {lost, done}, 2'b10);

    // R7 next start clears lost
    fb[0] = 8'h00;
    run_frame(1, 3, 0);
    chk(l1 == 1'b0 && dn1 == 1'b0, "R7 start clears flags", {l1, dn1}, 0);
    chk(lost == 1'b1 && busy == 1'b0 && bus_drive == 1'b0, "R6 stretched active loses",
        {lost, busy, bus_drive}, 3'b100);
    chk(rises == 2, "R6 rises before loss", rises, 2);
    chk(exitc > xmark + 64 * D && exitc <= xmark + 64 * D + 17 * D + 4,
        "R6 loss after grace", exitc - xmark, 64 * D + 16 * D);

    // R8 no echo
    stuck = 1'b1;
    fb[0] = 8'hFF;
    run_frame(1, 0, 0);
    chk(l1 == 1'b0, "R7 lost cleared by start", int'(l1), 0);
    chk(no_echo == 1'b1 && busy == 1'b0 && bus_drive == 1'b0, "R8 no_echo raised",
        {no_echo, busy, bus_drive}, 3'b100);
    chk(lost == 1'b0 && done == 1'b0, "R8 only no_echo", {lost, done}, 0);
    chk(nts >= 2 && ((ts[1] - ts[0]) + D - 1) / D == 60, "R8 echo window ticks",
        ((ts[1] - ts[0]) + D - 1) / D, 60);
    repeat (20) @(negedge clk);
    chk(no_echo == 1'b1, "R7 no_echo held", int'(no_echo), 1);
    stuck = 1'b0;

    fb[0] = 8'h69;
    run_frame(1, 0, 0);
    chk(ne1 == 1'b0, "R7 no_echo cleared by start", int'(ne1), 0);
    check_normal(1, "R3");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule